// File: doc/BRIEF.md
# Synthesizer Divider and Charge-Pump Control

This block is the digital core of a tuner frequency synthesizer. One counter divides crystal-clock enables by a reference ratio of 512, 640 or 1024, picked by two select inputs. A second counter divides enables from the prescaled oscillator by a 15-bit programmable value N. The prescaler ahead of it divides by a fixed eight and sits outside the block. A three-state phase/frequency detector compares the two divided events and produces up and down pulses.

A lock detector watches how long those pulses last in each comparison period and raises an in-lock flag. Control logic turns the three test-mode bits, the current-select bit and the lock state into the pump enable, pump direction and high/low current outputs. It also drives an active-low flag that shows when the automatic low-current switch is in effect.

A monitor pin carries one of three signals: the comparison clock, half the divided oscillator clock, or, in three-wire bus mode, an active-low lock indication. The tuning-amplifier disable bit is passed through to its output. The whole block runs from one system clock, and both counting inputs are single-cycle enables.

Top module: `synth_core`

## Requirements
- R1: The reference counter produces one comparison event per R enables of `ref_tick`. R is 640 when `ratio_sel_b`=0, whatever `ratio_sel_a` is. R is 1024 when `ratio_sel_a`=0 and `ratio_sel_b`=1. R is 512 when both are 1.
- R2: The programmable counter produces one divider event per N enables of `vco_tick`, where N is the 15-bit value `n_div`. Values of N below 2 divide by 2.
- R3: `pfd_up` rises on a comparison event and `pfd_dn` rises on a divider event. When both would be high, both clear in that same cycle, so the two outputs are never high together.
- R4: `in_lock` rises after 4 consecutive comparison periods in which the total up/down high time is below `lock_thr` cycles. It falls at the first comparison period that reaches the threshold, so `lock_thr`=0 always drops lock.
- R5: Test code `test_mode`=3'b010 or 3'b011 holds `pump_en` at 0.
- R6: Test code 3'b110 holds the pump on and sinking (`pump_en`=1, `pump_src`=0). Code 3'b111 holds it on and sourcing (`pump_en`=1, `pump_src`=1).
- R7: For codes 3'b000, 3'b001, 3'b100 and 3'b101, `pump_en` = `pfd_up` | `pfd_dn` and `pump_src` = `pfd_up`.
- R8: `pump_hi` follows `cp_high` (1 = high current), except that it is 0 whenever `auto_sw_flag` is 0.
- R9: `auto_sw_flag` is 0 exactly when `test_mode`=3'b001 (automatic switch) and `in_lock`=1; otherwise it is 1.
- R10: Code 3'b100 drives the comparison clock on `mon_out`, with a period of R enables. Code 3'b101 drives half the divider clock, with a period of 2N enables. Both codes set `mon_oe`=1. Under any other code, `three_wire`=1 gives `mon_oe`=1 and `mon_out` = not `in_lock`, while `three_wire`=0 gives `mon_oe`=0 and `mon_out`=0.
- R11: `tune_hiz` equals `tune_off`: 1 puts the tuning output in high impedance.
- R12: During reset `in_lock`, `pfd_up`, `pfd_dn` and `pump_en` are 0. With `test_mode`=3'b001 and `cp_high`=1, `auto_sw_flag` and `pump_hi` are 1 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Crystal-clock enable |
| vco_tick | input | 1 | Prescaled oscillator enable |
| n_div | input | 15 | Programmable divide value N |
| ratio_sel_a | input | 1 | Reference ratio select, bit A |
| ratio_sel_b | input | 1 | Reference ratio select, bit B |
| test_mode | input | 3 | Test/pump mode code |
| cp_high | input | 1 | Pump current select, 1 = high |
| tune_off | input | 1 | Tuning amplifier disable |
| three_wire | input | 1 | 1 = three-wire bus mode |
| lock_thr | input | 8 | Lock pulse-width threshold in cycles |
| pfd_up | output | 1 | Detector up pulse |
| pfd_dn | output | 1 | Detector down pulse |
| pump_en | output | 1 | Charge pump enable |
| pump_src | output | 1 | Pump direction, 1 = source |
| pump_hi | output | 1 | Pump current, 1 = high |
| auto_sw_flag | output | 1 | 0 when automatic low current is in effect |
| in_lock | output | 1 | Lock flag |
| mon_out | output | 1 | Monitor pin value |
| mon_oe | output | 1 | Monitor pin drive enable |
| tune_hiz | output | 1 | Tuning output high-impedance control |

## Verification
The properties assume that `test_mode` and `cp_high` come from settled control registers. They also assume that `ref_tick` and `vco_tick` are single-cycle enables in the system clock domain. The stimulus changes control inputs only at the falling clock edge and holds them for whole cycles. It drives both enables every cycle, so that divider periods are counted in clock cycles. Changes to the ratio or N are made mid-run; the bench waits out one full period before measuring, so only settled periods are compared with the expected ratio.

// File: rtl/synth_pkg.sv
package synth_pkg;

    typedef enum logic [2:0] {
        TM_MANUAL = 3'b000,
        TM_AUTO   = 3'b001,
        TM_OFF_A  = 3'b010,
        TM_OFF_B  = 3'b011,
        TM_REFMON = 3'b100,
        TM_DIVMON = 3'b101,
        TM_SINK   = 3'b110,
        TM_SOURCE = 3'b111
    } tmode_e;

    localparam int unsigned RATIO_SHORT = 512;
    localparam int unsigned RATIO_MID   = 640;
    localparam int unsigned RATIO_LONG  = 1024;

    // Select B low wins; otherwise select A picks the short ratio.
    function automatic int unsigned ratio_pick(input logic sel_a, input logic sel_b);
        if (!sel_b)
            return RATIO_MID;
        else if (sel_a)
            return RATIO_SHORT;
        else
            return RATIO_LONG;
    endfunction

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel_a,
    input  logic sel_b,
    output logic cmp_ev,
    output logic cmp_sq
);
    import synth_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ev;
        logic             sq;
    } rdiv_t;

    rdiv_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] half;

    always_comb begin
        lim  = CNT_W'(ratio_pick(sel_a, sel_b) - 1);
        half = CNT_W'(ratio_pick(sel_a, sel_b) / 2);
        st_d    = st_q;
        st_d.ev = 1'b0;
        if (tick) begin
            if (st_q.cnt >= lim) begin
                st_d.cnt = '0;
                st_d.ev  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        st_d.sq = (st_d.cnt >= half);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cmp_ev = st_q.ev;
    assign cmp_sq = st_q.sq;
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
    parameter int N_W = 15
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] n_val,
    output logic           div_ev,
    output logic           div_half
);
    localparam logic [N_W-1:0] N_MIN = N_W'(2);

    typedef struct packed {
        logic [N_W-1:0] cnt;
        logic           ev;
        logic           half;
    } pdiv_t;

    pdiv_t st_d, st_q;
    logic [N_W-1:0] n_eff;

    always_comb begin
        n_eff   = (n_val < N_MIN) ? N_MIN : n_val;
        st_d    = st_q;
        st_d.ev = 1'b0;
        if (tick) begin
            if (st_q.cnt >= n_eff - 1'b1) begin
                st_d.cnt = '0;
                st_d.ev  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (st_d.ev)
            st_d.half = ~st_q.half;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign div_ev   = st_q.ev;
    assign div_half = st_q.half;
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic div_ev,
    output logic up,
    output logic dn
);
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_t;

    pfd_t st_d, st_q;
    logic up_n, dn_n;

    always_comb begin
        up_n = st_q.up | ref_ev;
        dn_n = st_q.dn | div_ev;
        if (up_n && dn_n) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end else begin
            st_d.up = up_n;
            st_d.dn = dn_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
    parameter int W_W    = 8,
    parameter int GOOD_N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_ev,
    input  logic           up,
    input  logic           dn,
    input  logic [W_W-1:0] thr,
    output logic           locked
);
    localparam int GOOD_W = $clog2(GOOD_N + 1);
    localparam logic [GOOD_W-1:0] GOOD_LIM = GOOD_W'(GOOD_N);

    typedef struct packed {
        logic [W_W-1:0]    wcnt;
        logic [GOOD_W-1:0] good;
        logic              locked;
    } lock_t;

    lock_t st_d, st_q;
    logic  period_ok;

    always_comb begin
        st_d      = st_q;
        period_ok = (st_q.wcnt < thr);
        if ((up || dn) && (st_q.wcnt != '1))
            st_d.wcnt = st_q.wcnt + 1'b1;
        if (ref_ev) begin
            st_d.wcnt = '0;
            if (period_ok) begin
                if (st_q.good != GOOD_LIM)
                    st_d.good = st_q.good + 1'b1;
                st_d.locked = (st_d.good == GOOD_LIM);
            end else begin
                st_d.good   = '0;
                st_d.locked = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign locked = st_q.locked;
endmodule

// File: rtl/synth_cp_ctrl.sv
module synth_cp_ctrl (
    input  logic [2:0] test_mode,
    input  logic       cp_high,
    input  logic       up,
    input  logic       dn,
    input  logic       locked,
    input  logic       ref_sq,
    input  logic       div_half,
    input  logic       three_wire,
    output logic       pump_en,
    output logic       pump_src,
    output logic       pump_hi,
    output logic       auto_flag,
    output logic       mon_out,
    output logic       mon_oe
);
    import synth_pkg::*;

    tmode_e mode;

    always_comb begin
        mode      = tmode_e'(test_mode);
        auto_flag = !((mode == TM_AUTO) && locked);
        pump_hi   = cp_high && auto_flag;
        pump_en   = up || dn;
        pump_src  = up;
        mon_oe    = three_wire;
        mon_out   = three_wire && !locked;
        unique case (mode)
            TM_OFF_A, TM_OFF_B: begin
                pump_en  = 1'b0;
                pump_src = 1'b0;
            end
            TM_SINK: begin
                pump_en  = 1'b1;
                pump_src = 1'b0;
            end
            TM_SOURCE: begin
                pump_en  = 1'b1;
                pump_src = 1'b1;
            end
            TM_REFMON: begin
                mon_oe  = 1'b1;
                mon_out = ref_sq;
            end
            TM_DIVMON: begin
                mon_oe  = 1'b1;
                mon_out = div_half;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/synth_core.sv
module synth_core #(
    parameter int REF_W  = 10,
    parameter int N_W    = 15,
    parameter int W_W    = 8,
    parameter int GOOD_N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic           vco_tick,
    input  logic [N_W-1:0] n_div,
    input  logic           ratio_sel_a,
    input  logic           ratio_sel_b,
    input  logic [2:0]     test_mode,
    input  logic           cp_high,
    input  logic           tune_off,
    input  logic           three_wire,
    input  logic [W_W-1:0] lock_thr,
    output logic           pfd_up,
    output logic           pfd_dn,
    output logic           pump_en,
    output logic           pump_src,
    output logic           pump_hi,
    output logic           auto_sw_flag,
    output logic           in_lock,
    output logic           mon_out,
    output logic           mon_oe,
    output logic           tune_hiz
);
    logic cmp_ev, cmp_sq, div_ev, div_half;

    synth_ref_div #(.CNT_W(REF_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick),
        .sel_a(ratio_sel_a), .sel_b(ratio_sel_b),
        .cmp_ev(cmp_ev), .cmp_sq(cmp_sq)
    );

    synth_prog_div #(.N_W(N_W)) u_prog (
        .clk(clk), .rst_n(rst_n), .tick(vco_tick), .n_val(n_div),
        .div_ev(div_ev), .div_half(div_half)
    );

    synth_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_ev(cmp_ev), .div_ev(div_ev),
        .up(pfd_up), .dn(pfd_dn)
    );

    synth_lock_det #(.W_W(W_W), .GOOD_N(GOOD_N)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_ev(cmp_ev), .up(pfd_up), .dn(pfd_dn),
        .thr(lock_thr), .locked(in_lock)
    );

    synth_cp_ctrl u_cp (
        .test_mode(test_mode), .cp_high(cp_high), .up(pfd_up), .dn(pfd_dn),
        .locked(in_lock), .ref_sq(cmp_sq), .div_half(div_half),
        .three_wire(three_wire), .pump_en(pump_en), .pump_src(pump_src),
        .pump_hi(pump_hi), .auto_flag(auto_sw_flag), .mon_out(mon_out),
        .mon_oe(mon_oe)
    );

    assign tune_hiz = tune_off;
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] test_mode,
    input logic       three_wire,
    input logic       pfd_up,
    input logic       pfd_dn,
    input logic       pump_en,
    input logic       pump_src,
    input logic       pump_hi,
    input logic       auto_sw_flag,
    input logic       in_lock,
    input logic       mon_oe
);
    // R3
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfd_up && pfd_dn));
    // R5
    a_r5_pump_off: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode[2:1] == 2'b01) |-> !pump_en);
    // R6
    a_r6_force_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 3'b110) |-> (pump_en && !pump_src));
    a_r6_force_source: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 3'b111) |-> (pump_en && pump_src));
    // R7
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode[1] && !pfd_up && !pfd_dn) |-> !pump_en);
    // R8
    a_r8_auto_low: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_sw_flag |-> !pump_hi);
    // R9
    a_r9_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != 3'b001) |-> auto_sw_flag);
    a_r9_flag_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_sw_flag |-> in_lock);
    // R10
    a_r10_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!three_wire && (test_mode[2:1] != 2'b10)) |-> !mon_oe);
endmodule

bind synth_core synth_core_chk chk_i (.*);

// File: tb/synth_core_tb_top.sv
module synth_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick, vco_tick;
    logic [14:0] n_div;
    logic        ratio_sel_a, ratio_sel_b;
    logic [2:0]  test_mode;
    logic        cp_high, tune_off, three_wire;
    logic [7:0]  lock_thr;
    logic        pfd_up, pfd_dn, pump_en, pump_src, pump_hi;
    logic        auto_sw_flag, in_lock, mon_out, mon_oe, tune_hiz;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_core dut_i (.*);

    // {mode[2:0], cp, exp_en, exp_src, exp_hi, exp_flag}, loop locked
    localparam logic [7:0] VEC [10] = '{
        8'b000_1_0011, 8'b000_0_0001, 8'b001_1_0000, 8'b001_0_0000,
        8'b010_1_0011, 8'b011_0_0001, 8'b110_1_1011, 8'b111_0_1101,
        8'b111_1_1111, 8'b100_1_0011
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int per);
        bit prev;
        per = 0;
        prev = mon_out;
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            if (!prev && mon_out) break;
            prev = mon_out;
        end
        prev = mon_out;
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            per++;
            if (!prev && mon_out) break;
            prev = mon_out;
        end
    endtask

    task automatic period_check(input string req, input int exp);
        int p;
        measure(p);
        measure(p);
        check(p == exp, req, p, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seen_overlap;
        bit got;
        rst_n = 1'b0; ref_tick = 1'b1; vco_tick = 1'b1; n_div = 15'd512;
        ratio_sel_a = 1'b1; ratio_sel_b = 1'b1; test_mode = 3'b001;
        cp_high = 1'b1; tune_off = 1'b1; three_wire = 1'b1; lock_thr = 8'd4;
        cycles(3);
        // R12 reset state
        check(!in_lock && !pfd_up && !pfd_dn && !pump_en, "R12 reset outputs",
              {in_lock, pfd_up, pfd_dn, pump_en}, 0);
        check(auto_sw_flag && pump_hi, "R12 reset flag/current", {auto_sw_flag, pump_hi}, 3);
        check(mon_oe && mon_out, "R10 reset three-wire lock pin", {mon_oe, mon_out}, 3);
        check(tune_hiz == 1'b1, "R11 tune off", tune_hiz, 1);

        // R4: lock after four good periods
        @(negedge clk); rst_n = 1'b1;
        cycles(3*512 + 100);
        check(!in_lock, "R4 not locked after three periods", in_lock, 0);
        cycles(512);
        check(in_lock, "R4 locked after four periods", in_lock, 1);
        check(!auto_sw_flag && !pump_hi, "R9 R8 auto low current when locked",
              {auto_sw_flag, pump_hi}, 0);
        check(!mon_out && mon_oe, "R10 three-wire lock pin low", mon_out, 0);

        // Decode table, loop locked and aligned
        foreach (VEC[i]) begin
            @(negedge clk);
            test_mode = VEC[i][7:5];
            cp_high   = VEC[i][4];
            #1;
            check(pump_en == VEC[i][3], "R5 R6 R7 pump_en", pump_en, VEC[i][3]);
            check(pump_src == VEC[i][2], "R6 R7 pump_src", pump_src, VEC[i][2]);
            check(pump_hi == VEC[i][1], "R8 pump_hi", pump_hi, VEC[i][1]);
            check(auto_sw_flag == VEC[i][0], "R9 auto_sw_flag", auto_sw_flag, VEC[i][0]);
        end

        @(negedge clk);
        tune_off = 1'b0; test_mode = 3'b001; three_wire = 1'b0; cp_high = 1'b1;
        #1;
        check(tune_hiz == 1'b0, "R11 tune on", tune_hiz, 0);
        check(!mon_oe && !mon_out, "R10 two-wire pin released", {mon_oe, mon_out}, 0);

        // R4 threshold boundary: zero never passes
        @(negedge clk); lock_thr = 8'd0;
        cycles(600);
        check(!in_lock, "R4 zero threshold drops lock", in_lock, 0);
        @(negedge clk); lock_thr = 8'd4;
        cycles(4*512 + 100);
        check(in_lock, "R4 relock after threshold restored", in_lock, 1);

        // R4 drop on mismatch, R7 down pulse drives pump
        @(negedge clk); n_div = 15'd400;
        cycles(1100);
        check(!in_lock, "R4 lock lost on mismatch", in_lock, 0);
        check(auto_sw_flag, "R9 flag high when unlocked", auto_sw_flag, 1);
        got = 0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (pfd_dn) begin got = 1; break; end
        end
        check(got && pump_en && !pump_src && pump_hi, "R7 R3 down pulse sinks at high current",
              {got, pump_en, pump_src, pump_hi}, 4'b1101);

        @(negedge clk); n_div = 15'd600;
        got = 0;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (pfd_up) begin got = 1; break; end
        end
        check(got && pump_en && pump_src, "R7 R3 up pulse sources",
              {got, pump_en, pump_src}, 3'b111);

        seen_overlap = 0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (pfd_up && pfd_dn) seen_overlap++;
        end
        check(seen_overlap == 0, "R3 up and down never together", seen_overlap, 0);

        // Periods on the monitor pin
        @(negedge clk); test_mode = 3'b100; n_div = 15'd512;
        period_check("R1 R10 ratio 512", 512);
        @(negedge clk); ratio_sel_b = 1'b0;
        period_check("R1 ratio 640 (B low, A high)", 640);
        @(negedge clk); ratio_sel_a = 1'b0;
        period_check("R1 ratio 640 (B low, A low)", 640);
        @(negedge clk); ratio_sel_b = 1'b1;
        period_check("R1 ratio 1024", 1024);
        @(negedge clk); test_mode = 3'b101;
        check(mon_oe, "R10 divider monitor enabled", mon_oe, 1);
        period_check("R2 R10 half divider N=512", 1024);
        @(negedge clk); n_div = 15'd300;
        period_check("R2 N=300", 600);
        @(negedge clk); n_div = 15'd1;
        period_check("R2 N=1 treated as 2", 4);
        @(negedge clk); n_div = 15'd0;
        period_check("R2 N=0 treated as 2", 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule